// File: doc/BRIEF.md
# Stream Width Repacker

This block takes a valid/ready stream of `W_IN`-bit words and re-slices it into a valid/ready stream of `W_OUT`-bit words. The two widths are free parameters, and their ratio need not be an integer: 3 to 7 works as well as 16 to 8 or 12 to 64. The input is treated as one unbroken bit sequence, least significant bit first. Output words are cut from that sequence in order, so an input word may be split across two or more output words.

A packet-end flag arrives with each input word. It is carried to the one output word that contains the final bit of the flagged input word. Either side may stall on any cycle. The block runs on a single clock, and it never pads a partial word at the end of a packet. Any bits that do not yet form a full output word wait until later input completes them.

Top module: `stream_repacker`

## Requirements
- R1: Packing is LSB-first. Bit 0 of the first accepted input word becomes bit 0 of the first output word, and each later input bit takes the next more significant position in the output sequence.
- R2: With `W_IN`=3 and `W_OUT`=7, the inputs 001, 010, 100, 011, 110, 111, 000 yield exactly three outputs: 0b0010001, 0b1001110, 0b0001111.
- R3: With `W_IN`=16 and `W_OUT`=8, each input word produces its low byte first and its high byte second.
- R4: `out_last` is 1 only on the output word that holds the final bit of an input word accepted with `in_last`=1. For example, 8 to 4 with input 0b00100001 and last=1 gives 0001 with last=0, then 0010 with last=1.
- R5: The number of output words emitted with `out_last`=1 equals the number of input words accepted with `in_last`=1. No output word carries the flag before a flagged input has been accepted for it.
- R6: Under arbitrary stalls of `in_valid` and `out_ready`, every input bit appears in the output exactly once and in order.
- R7: Once `out_valid` is 1, it stays 1, and `out_data` and `out_last` hold their values, until a cycle in which `out_ready` is 1.
- R8: While `rst` is 1 at a clock edge, the next cycle shows `out_valid`=0 and `in_ready`=1, and no stored data remains.
- R9: `in_ready` is 1 whenever `out_valid` is 0, so the block can always make progress.
- R10: A 12-to-48 repacker followed by a 48-to-64 repacker produces the same 64-bit word sequence as a direct 12-to-64 repacker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_data | input | W_IN | Input word |
| in_last | input | 1 | Packet end flag of the input word |
| out_valid | output | 1 | Output word is offered |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_data | output | W_OUT | Output word |
| out_last | output | 1 | Output word completes a flagged input word |

## Verification
The bound checker watches, on every cycle, the output hold rule, the guarantee that the input side is open whenever no output is offered, the idle state after reset, and the rule that no flagged output appears unless a flagged input is outstanding. The bit order, the exact split points at ratios that are not integers, the exact word that carries each flag, loss-free transfer under random two-sided stalls, and the equivalence of a chained conversion with a direct one all depend on whole sequences. Only the directed scenarios in the bench can show these.

// File: rtl/stream_repacker.sv
module stream_repacker #(
  parameter int W_IN  = 12,
  parameter int W_OUT = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W_IN-1:0]  in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W_OUT-1:0] out_data,
  output logic             out_last
);
  localparam int DEPTH = W_IN + W_OUT;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] bits_q, mark_q, bits_s, mark_s, bits_n, mark_n;
  logic [CW-1:0]    fill_q, fill_s, fill_n;
  logic             take, give;

  assign out_valid = fill_q >= CW'(W_OUT);
  assign in_ready  = fill_q <= CW'(W_OUT);
  assign out_data  = bits_q[W_OUT-1:0];
  assign out_last  = |mark_q[W_OUT-1:0];
  assign take      = in_valid & in_ready;
  assign give      = out_valid & out_ready;

  always_comb begin
    bits_s = give ? bits_q >> W_OUT : bits_q;
    mark_s = give ? mark_q >> W_OUT : mark_q;
    fill_s = give ? fill_q - CW'(W_OUT) : fill_q;
    bits_n = bits_s;
    mark_n = mark_s;
    fill_n = fill_s;
    if (take) begin
      bits_n = bits_s | ({{W_OUT{1'b0}}, in_data} << fill_s);
      mark_n = mark_s | (DEPTH'(in_last) << (fill_s + CW'(W_IN - 1)));
      fill_n = fill_s + CW'(W_IN);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      mark_q <= '0;
      fill_q <= '0;
    end else begin
      bits_q <= bits_n;
      mark_q <= mark_n;
      fill_q <= fill_n;
    end
  end
endmodule

// File: rtl/stream_repacker_checks.sv
module stream_repacker_checks #(
  parameter int W_IN  = 12,
  parameter int W_OUT = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W_OUT-1:0] out_data,
  input logic             out_last
);
  logic [15:0] pend;
  logic        in_flag, out_flag;

  assign in_flag  = in_valid & in_ready & in_last;
  assign out_flag = out_valid & out_ready & out_last;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend + 16'(in_flag) - 16'(out_flag);
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R7
  AST_NO_STARVE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R9
  AST_FLAG_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    out_flag |-> pend != 16'd0); // R5
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !out_valid && in_ready); // R8
endmodule

bind stream_repacker stream_repacker_checks #(.W_IN(W_IN), .W_OUT(W_OUT)) u_checks (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/test_stream_repacker.sv
`timescale 1ns/1ps
module test_stream_repacker;
  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // 3 -> 7
  logic a_iv = 0, a_ir, a_il = 0, a_ov, a_rdy = 0, a_ol;
  logic [2:0] a_id = 0;
  logic [6:0] a_od;
  stream_repacker #(.W_IN(3), .W_OUT(7)) i_stream_repacker (
    .clk(clk), .rst(rst), .in_valid(a_iv), .in_ready(a_ir), .in_data(a_id), .in_last(a_il),
    .out_valid(a_ov), .out_ready(a_rdy), .out_data(a_od), .out_last(a_ol));

  // 16 -> 8
  logic b_iv = 0, b_ir, b_ov, b_rdy = 0, b_ol;
  logic [15:0] b_id = 0;
  logic [7:0] b_od;
  stream_repacker #(.W_IN(16), .W_OUT(8)) u_b (
    .clk(clk), .rst(rst), .in_valid(b_iv), .in_ready(b_ir), .in_data(b_id), .in_last(1'b0),
    .out_valid(b_ov), .out_ready(b_rdy), .out_data(b_od), .out_last(b_ol));

  // 8 -> 4
  logic c_iv = 0, c_ir, c_il = 0, c_ov, c_rdy = 0, c_ol;
  logic [7:0] c_id = 0;
  logic [3:0] c_od;
  stream_repacker #(.W_IN(8), .W_OUT(4)) u_c (
    .clk(clk), .rst(rst), .in_valid(c_iv), .in_ready(c_ir), .in_data(c_id), .in_last(c_il),
    .out_valid(c_ov), .out_ready(c_rdy), .out_data(c_od), .out_last(c_ol));

  // 16 -> 4
  logic d_iv = 0, d_ir, d_il = 0, d_ov, d_rdy = 0, d_ol;
  logic [15:0] d_id = 0;
  logic [3:0] d_od;
  stream_repacker #(.W_IN(16), .W_OUT(4)) u_d (
    .clk(clk), .rst(rst), .in_valid(d_iv), .in_ready(d_ir), .in_data(d_id), .in_last(d_il),
    .out_valid(d_ov), .out_ready(d_rdy), .out_data(d_od), .out_last(d_ol));

  // 12 -> 48 -> 64 chain and 12 -> 64 direct
  logic e_iv = 0, e_ir, m_v, m_r, m_l, e_ov, e_rdy = 0, e_ol;
  logic [11:0] e_id = 0;
  logic [47:0] m_d;
  logic [63:0] e_od;
  stream_repacker #(.W_IN(12), .W_OUT(48)) u_e1 (
    .clk(clk), .rst(rst), .in_valid(e_iv), .in_ready(e_ir), .in_data(e_id), .in_last(1'b0),
    .out_valid(m_v), .out_ready(m_r), .out_data(m_d), .out_last(m_l));
  stream_repacker #(.W_IN(48), .W_OUT(64)) u_e2 (
    .clk(clk), .rst(rst), .in_valid(m_v), .in_ready(m_r), .in_data(m_d), .in_last(m_l),
    .out_valid(e_ov), .out_ready(e_rdy), .out_data(e_od), .out_last(e_ol));

  logic f_iv = 0, f_ir, f_ov, f_rdy = 0, f_ol;
  logic [11:0] f_id = 0;
  logic [63:0] f_od;
  stream_repacker #(.W_IN(12), .W_OUT(64)) u_f (
    .clk(clk), .rst(rst), .in_valid(f_iv), .in_ready(f_ir), .in_data(f_id), .in_last(1'b0),
    .out_valid(f_ov), .out_ready(f_rdy), .out_data(f_od), .out_last(f_ol));

  task automatic test_reset();
    @(negedge clk);
    check(!a_ov, "R8 out_valid after reset", 64'(a_ov), 0);
    check(a_ir, "R8 in_ready after reset", 64'(a_ir), 1);
    check(!d_ov && d_ir, "R8 idle 16to4 after reset", 64'({d_ov, d_ir}), 64'b01);
  endtask

  task automatic test_three_to_seven();
    logic [2:0] src [7] = '{3'b001, 3'b010, 3'b100, 3'b011, 3'b110, 3'b111, 3'b000};
    logic [6:0] exp [3] = '{7'b0010001, 7'b1001110, 7'b0001111};
    logic [6:0] held = 0;
    int idx = 0, got = 0;
    for (int cyc = 0; cyc < 80 && got < 3; cyc++) begin
      @(negedge clk);
      a_iv = idx < 7;
      a_id = (idx < 7) ? src[idx] : 3'b0;
      a_rdy = cyc >= 6;
      #1;
      if (cyc == 3) held = a_od;
      if (cyc == 5) begin
        check(a_ov && a_od == held, "R7 output held while stalled", 64'(a_od), 64'(held));
        check(!a_ir, "R9 input closed while full and stalled", 64'(a_ir), 0);
      end
      if (a_iv && a_ir) idx++;
      if (a_ov && a_rdy) begin
        check(a_od == exp[got], got == 0 ? "R1 first word LSB-first" : "R2 split across words",
              64'(a_od), 64'(exp[got]));
        got++;
      end
    end
    @(negedge clk);
    a_iv = 0; a_rdy = 0;
    check(got == 3, "R2 output word count", 64'(got), 3);
    #1;
    check(!a_ov, "R2 no extra word", 64'(a_ov), 0);
  endtask

  task automatic test_sixteen_to_eight();
    int idx = 0, got = 0, bad = 0;
    logic [7:0] first_bad = 0, first_exp = 0;
    for (int cyc = 0; cyc < 2000 && got < 100; cyc++) begin
      @(negedge clk);
      b_iv = (idx < 50) && ($urandom % 4 != 0);
      b_id = {8'(2 * idx + 1), 8'(2 * idx)};
      b_rdy = $urandom % 3 != 0;
      #1;
      if (b_iv && b_ir) idx++;
      if (b_ov && b_rdy) begin
        if (b_od != 8'(got) && bad == 0) begin first_bad = b_od; first_exp = 8'(got); end
        if (b_od != 8'(got)) bad++;
        got++;
      end
    end
    @(negedge clk);
    b_iv = 0; b_rdy = 0;
    check(bad == 0, "R3 low byte first under stalls", 64'(first_bad), 64'(first_exp));
    check(got == 100, "R6 no loss or duplication 16to8", 64'(got), 100);
  endtask

  task automatic test_eight_to_four_last();
    logic [7:0] src [2] = '{8'b00100001, 8'b10000100};
    logic       srl [2] = '{1'b1, 1'b0};
    logic [4:0] exp [4] = '{5'b0001_0, 5'b0010_1, 5'b0100_0, 5'b1000_0};
    int idx = 0, got = 0;
    for (int cyc = 0; cyc < 40 && got < 4; cyc++) begin
      @(negedge clk);
      c_iv = idx < 2;
      c_id = (idx < 2) ? src[idx] : 8'b0;
      c_il = (idx < 2) ? srl[idx] : 1'b0;
      c_rdy = 1;
      #1;
      if (c_iv && c_ir) idx++;
      if (c_ov && c_rdy) begin
        check({c_od, c_ol} == exp[got], "R4 flag on completing word", 64'({c_od, c_ol}), 64'(exp[got]));
        got++;
      end
    end
    @(negedge clk);
    c_iv = 0; c_il = 0; c_rdy = 0;
    check(got == 4, "R4 word count 8to4", 64'(got), 4);
  endtask

  task automatic test_flag_count();
    int idx = 0, got = 0, flags = 0, misplaced = 0;
    for (int cyc = 0; cyc < 4000 && got < 200; cyc++) begin
      @(negedge clk);
      d_iv = (idx < 50) && ($urandom % 3 != 0);
      d_id = 16'(idx);
      d_il = (idx % 5) == 0;
      d_rdy = $urandom % 4 != 0;
      #1;
      if (d_iv && d_ir) idx++;
      if (d_ov && d_rdy) begin
        if (d_ol) flags++;
        if (d_ol != ((got % 4 == 3) && ((got / 4) % 5 == 0))) misplaced++;
        if (d_od != 4'(idx >= 0 ? (got / 4) >> (4 * (got % 4)) : 0)) misplaced++;
        got++;
      end
    end
    @(negedge clk);
    d_iv = 0; d_il = 0; d_rdy = 0;
    check(flags == 10, "R5 flag count preserved", 64'(flags), 10);
    check(misplaced == 0, "R4 flag position and data 16to4", 64'(misplaced), 0);
    check(got == 200, "R6 no loss or duplication 16to4", 64'(got), 200);
  endtask

  task automatic test_chain_vs_direct();
    logic [11:0] src [48];
    logic [63:0] exp [9], chain [9], direct [9];
    int idx, got;
    for (int i = 0; i < 48; i++) src[i] = 12'($urandom);
    for (int k = 0; k < 9; k++)
      for (int j = 0; j < 64; j++) exp[k][j] = src[(64 * k + j) / 12][(64 * k + j) % 12];
    idx = 0; got = 0;
    for (int cyc = 0; cyc < 3000 && got < 9; cyc++) begin
      @(negedge clk);
      e_iv = (idx < 48) && ($urandom % 3 != 0);
      e_id = (idx < 48) ? src[idx] : 12'b0;
      e_rdy = $urandom % 2 == 0;
      #1;
      if (e_iv && e_ir) idx++;
      if (e_ov && e_rdy) begin chain[got] = e_od; got++; end
    end
    @(negedge clk);
    e_iv = 0; e_rdy = 0;
    check(got == 9, "R10 chain word count", 64'(got), 9);
    idx = 0; got = 0;
    for (int cyc = 0; cyc < 3000 && got < 9; cyc++) begin
      @(negedge clk);
      f_iv = (idx < 48) && ($urandom % 2 == 0);
      f_id = (idx < 48) ? src[idx] : 12'b0;
      f_rdy = $urandom % 3 != 0;
      #1;
      if (f_iv && f_ir) idx++;
      if (f_ov && f_rdy) begin direct[got] = f_od; got++; end
    end
    @(negedge clk);
    f_iv = 0; f_rdy = 0;
    check(got == 9, "R6 direct word count", 64'(got), 9);
    for (int k = 0; k < 9; k++) begin
      check(direct[k] == exp[k], "R1 direct 12to64 bit order", direct[k], exp[k]);
      check(chain[k] == direct[k], "R10 chain equals direct", chain[k], direct[k]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    test_reset();
    test_three_to_seven();
    test_sixteen_to_eight();
    test_eight_to_four_last();
    test_flag_count();
    test_chain_vs_direct();
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    check(!a_ov && a_ir, "R8 reset mid-run", 64'({a_ov, a_ir}), 64'b01);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule